// File: doc/BRIEF.md
# Clock-Pair Mismatch Error Detector

This block watches two asynchronous clock signals that should move in lockstep. Every rising edge of the count clock should be answered by a falling edge of the reference clock within a bounded number of system-clock cycles, and every falling edge of the reference clock should likewise be answered by a rising edge of the count clock. An edge that finds no partner in time is one mismatch. The block keeps a tally of mismatches and raises a sticky flag once the tally reaches three. A synchronous, active-high master reset clears the tally, any pending edge and the flag.

Both inputs pass through a two-flop synchroniser and an edge detector. A pairing state machine then tracks at most one unanswered edge. Its states are `P_IDLE` (nothing pending), `P_WAIT_REF` (a count rise awaits a reference fall) and `P_WAIT_CNT` (a reference fall awaits a count rise). Its transitions are: *open* (a lone edge in `P_IDLE` enters the matching wait state), *match* (the partner edge returns the machine to `P_IDLE`), *rearm* (a repeated edge of the pending kind, or a match arriving together with a new edge of the pending kind, keeps the wait state and restarts the age count), and *expire* (the age reaches its limit, and the machine returns to `P_IDLE`). A second state machine holds the tally in `T_NONE`, `T_ONE`, `T_TWO` and `T_TRIP`. Its only transition, *step*, advances one state per mismatch. `T_TRIP` is absorbing, and the flag is high in it.

Top module: `clk_pair_guard`

## Requirements
- R1: A count-clock rising edge with no reference-clock falling edge detected within WINDOW system-clock cycles after it adds exactly one mismatch.
- R2: A reference-clock falling edge with no count-clock rising edge detected within WINDOW cycles after it adds exactly one mismatch.
- R3: A partner edge detected 1 to WINDOW cycles after the pending edge clears it without a mismatch. A partner that comes WINDOW+1 cycles later does not match, and both edges then expire as two mismatches.
- R4: A count rise and a reference fall detected in the same cycle pair with each other and add no mismatch.
- R5: A second edge of the pending kind, detected before the partner, turns the older edge into one mismatch and opens a fresh window for the newer one. When a partner edge and a new edge of the pending kind are detected together, the partner matches the older edge and the newer edge opens a fresh window.
- R6: `mismatch_flag` goes high once three mismatches have been counted. The tally saturates at three, and the flag stays high through any later activity until reset.
- R7: While `rst` is high, at the next clock edge the flag goes low, the tally returns to zero and any pending edge is discarded.
- R8: Each input is sampled by two flops before edge detection. If a lone count rise is the third mismatch, and the input is first seen high at clock edge k, the flag is high after edge k+WINDOW+2 and low before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| cnt_clk_in | input | 1 | Count clock, asynchronous, rising edges observed |
| ref_clk_in | input | 1 | Reference clock, asynchronous, falling edges observed |
| mismatch_flag | output | 1 | High once three mismatches have been counted |

## Verification
The hardest situations to reach from the ports are the rearm cases: a second count edge landing inside an open window, and a partner edge arriving in the same detected cycle as a new edge of the pending kind. The stimulus spaces pin changes in whole system-clock cycles. Because both synchronisers add the same delay, the spacing between detected edges equals the spacing of the pin changes, so those collisions can be placed exactly. The window boundary is handled the same way, with partners placed at exactly WINDOW and WINDOW+1 cycles. The flag is the only output, so each of these scenarios is repeated until three mismatches would, or would not, have accumulated.

// File: rtl/cpg_pkg.sv
package cpg_pkg;

    typedef enum logic [1:0] {
        P_IDLE     = 2'd0,
        P_WAIT_REF = 2'd1,
        P_WAIT_CNT = 2'd2
    } pair_state_t;

    typedef enum logic [1:0] {
        T_NONE = 2'd0,
        T_ONE  = 2'd1,
        T_TWO  = 2'd2,
        T_TRIP = 2'd3
    } tally_state_t;

endpackage

// File: rtl/cpg_edge_sync.sv
module cpg_edge_sync #(
    parameter bit DETECT_RISE = 1'b1,
    parameter int STAGES      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic edge_pulse
);
    // pipe[STAGES-1] is the synchronised level, pipe[STAGES] its previous value
    logic [STAGES:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-1:0], async_in};
    end

    generate
        if (DETECT_RISE) begin : g_rise
            assign edge_pulse = pipe[STAGES-1] & ~pipe[STAGES];
        end else begin : g_fall
            assign edge_pulse = ~pipe[STAGES-1] & pipe[STAGES];
        end
    endgenerate
endmodule

// File: rtl/cpg_pair_fsm.sv
module cpg_pair_fsm
    import cpg_pkg::*;
#(
    parameter int WINDOW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cnt_evt,
    input  logic                          ref_evt,
    output logic                          err_evt,
    output pair_state_t                   state_o,
    output logic [$clog2(WINDOW+1)-1:0]   age_o
);
    localparam int AW = $clog2(WINDOW + 1);
    localparam logic [AW-1:0] LAST = AW'(WINDOW - 1);

    pair_state_t   state_q, state_d;
    logic [AW-1:0] age_q, age_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= P_IDLE;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            age_q   <= age_d;
        end
    end

    // next state: open / match / rearm / expire
    always_comb begin
        state_d = state_q;
        age_d   = age_q;
        unique case (state_q)
            P_IDLE: begin
                age_d = '0;
                if (cnt_evt && !ref_evt)      state_d = P_WAIT_REF;
                else if (ref_evt && !cnt_evt) state_d = P_WAIT_CNT;
            end
            P_WAIT_REF: begin
                if (ref_evt) begin
                    if (cnt_evt) age_d = '0;
                    else         state_d = P_IDLE;
                end else if (cnt_evt) begin
                    age_d = '0;
                end else if (age_q == LAST) begin
                    state_d = P_IDLE;
                end else begin
                    age_d = age_q + 1'b1;
                end
            end
            P_WAIT_CNT: begin
                if (cnt_evt) begin
                    if (ref_evt) age_d = '0;
                    else         state_d = P_IDLE;
                end else if (ref_evt) begin
                    age_d = '0;
                end else if (age_q == LAST) begin
                    state_d = P_IDLE;
                end else begin
                    age_d = age_q + 1'b1;
                end
            end
            default: state_d = P_IDLE;
        endcase
    end

    // outputs: a mismatch on rearm-by-same-kind or on expiry
    always_comb begin
        err_evt = 1'b0;
        unique case (state_q)
            P_IDLE:     err_evt = 1'b0;
            P_WAIT_REF: err_evt = !ref_evt && (cnt_evt || age_q == LAST);
            P_WAIT_CNT: err_evt = !cnt_evt && (ref_evt || age_q == LAST);
            default:    err_evt = 1'b0;
        endcase
    end

    assign state_o = state_q;
    assign age_o   = age_q;
endmodule

// File: rtl/cpg_tally_fsm.sv
module cpg_tally_fsm
    import cpg_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         err_evt,
    output tally_state_t tally_o,
    output logic         flag
);
    tally_state_t tally_q, tally_d;

    always_ff @(posedge clk) begin
        if (rst) tally_q <= T_NONE;
        else     tally_q <= tally_d;
    end

    // step transition; T_TRIP absorbs
    always_comb begin
        tally_d = tally_q;
        unique case (tally_q)
            T_NONE:  if (err_evt) tally_d = T_ONE;
            T_ONE:   if (err_evt) tally_d = T_TWO;
            T_TWO:   if (err_evt) tally_d = T_TRIP;
            T_TRIP:  tally_d = T_TRIP;
            default: tally_d = T_NONE;
        endcase
    end

    always_comb begin
        flag = 1'b0;
        unique case (tally_q)
            T_TRIP:  flag = 1'b1;
            default: flag = 1'b0;
        endcase
    end

    assign tally_o = tally_q;
endmodule

// File: rtl/clk_pair_guard.sv
module clk_pair_guard
    import cpg_pkg::*;
#(
    parameter int WINDOW      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cnt_clk_in,
    input  logic ref_clk_in,
    output logic mismatch_flag
);
    localparam int AW = $clog2(WINDOW + 1);

    logic          cnt_evt;
    logic          ref_evt;
    logic          err_evt;
    pair_state_t   pair_state;
    logic [AW-1:0] age;
    tally_state_t  tally;

    cpg_edge_sync #(.DETECT_RISE(1'b1), .STAGES(SYNC_STAGES)) u_cnt_sync (
        .clk(clk), .rst(rst), .async_in(cnt_clk_in), .edge_pulse(cnt_evt)
    );

    cpg_edge_sync #(.DETECT_RISE(1'b0), .STAGES(SYNC_STAGES)) u_ref_sync (
        .clk(clk), .rst(rst), .async_in(ref_clk_in), .edge_pulse(ref_evt)
    );

    cpg_pair_fsm #(.WINDOW(WINDOW)) u_pair (
        .clk(clk), .rst(rst), .cnt_evt(cnt_evt), .ref_evt(ref_evt),
        .err_evt(err_evt), .state_o(pair_state), .age_o(age)
    );

    cpg_tally_fsm u_tally (
        .clk(clk), .rst(rst), .err_evt(err_evt),
        .tally_o(tally), .flag(mismatch_flag)
    );
endmodule

// File: rtl/cpg_guard_checker.sv
module cpg_guard_checker
    import cpg_pkg::*;
#(
    parameter int WINDOW = 8
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        cnt_evt,
    input logic                        ref_evt,
    input logic                        err_evt,
    input pair_state_t                 pair_state,
    input logic [$clog2(WINDOW+1)-1:0] age,
    input tally_state_t                tally,
    input logic                        mismatch_flag
);
    assert_tally_step_R1: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (tally == $past(tally)) || (int'(tally) == int'($past(tally)) + 1));

    assert_third_trips_R2: assert property (@(posedge clk) disable iff (rst)
        (err_evt && tally == T_TWO) |=> mismatch_flag);

    assert_age_bound_R3: assert property (@(posedge clk) disable iff (rst)
        (pair_state != P_IDLE) |-> (int'(age) < WINDOW));

    assert_match_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (pair_state == P_WAIT_REF && ref_evt && !cnt_evt) |=> (pair_state == P_IDLE));

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        (pair_state == P_IDLE) |-> !err_evt);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        mismatch_flag |=> mismatch_flag);

    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (!mismatch_flag && tally == T_NONE && pair_state == P_IDLE));
endmodule

bind clk_pair_guard cpg_guard_checker #(.WINDOW(WINDOW)) u_chk (
    .clk(clk), .rst(rst), .cnt_evt(cnt_evt), .ref_evt(ref_evt),
    .err_evt(err_evt), .pair_state(pair_state), .age(age),
    .tally(tally), .mismatch_flag(mismatch_flag)
);

// File: tb/clk_pair_guard_test.sv
module clk_pair_guard_test;
    localparam int WIN = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cnt_in = 1'b0;
    logic ref_in = 1'b1;
    logic flag;

    int compared = 0;
    int mismatched = 0;
    bit finished = 1'b0;

    // reference model state
    bit hc[$];
    bit hr[$];
    int m_pend = 0;   // 0 none, 1 count waiting, 2 reference waiting
    int m_age = 0;
    int m_err = 0;
    bit m_flag = 1'b0;

    always #5 clk = ~clk;

    clk_pair_guard #(.WINDOW(WIN)) uut (
        .clk(clk), .rst(rst), .cnt_clk_in(cnt_in), .ref_clk_in(ref_in),
        .mismatch_flag(flag)
    );

    always @(posedge clk) begin
        bit c, r;
        if (rst) begin
            hc = '{1'b0, 1'b0, 1'b0, 1'b0};
            hr = '{1'b0, 1'b0, 1'b0, 1'b0};
            m_pend = 0; m_age = 0; m_err = 0;
        end else begin
            hc.push_front(cnt_in); void'(hc.pop_back());
            hr.push_front(ref_in); void'(hr.pop_back());
            c = hc[2] && !hc[3];
            r = !hr[2] && hr[3];
            if (m_pend == 0) begin
                if (c && !r)      begin m_pend = 1; m_age = 0; end
                else if (r && !c) begin m_pend = 2; m_age = 0; end
            end else begin
                bit partner, same;
                partner = (m_pend == 1) ? r : c;
                same    = (m_pend == 1) ? c : r;
                if (partner) begin
                    if (same) m_age = 0; else m_pend = 0;
                end else if (same) begin
                    m_err++; m_age = 0;
                end else if (m_age == WIN - 1) begin
                    m_err++; m_pend = 0;
                end else begin
                    m_age++;
                end
            end
        end
        m_flag = (m_err >= 3);
    end

    // per-cycle comparison with the model (flag behaviour, R6)
    always @(negedge clk) begin
        if (!finished) begin
            compared++;
            if (flag !== m_flag) begin
                mismatched++;
                $display("FAIL R6 per-cycle flag at %0t: actual=%b expected=%b", $time, flag, m_flag);
            end
        end
    end

    task automatic check(string req, logic got, logic exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; cnt_in = 1'b0; ref_in = 1'b1;
        tick(3);
        check("R7 flag low during reset", flag, 1'b0);
        rst = 1'b0;
        tick(4);
    endtask

    task automatic pair(int d);
        cnt_in = 1'b1;
        if (d == 0) ref_in = 1'b0;
        else begin tick(d); ref_in = 1'b0; end
        tick(2);
        cnt_in = 1'b0; ref_in = 1'b1;
        tick(WIN + 6);
    endtask

    task automatic lone_cnt();
        cnt_in = 1'b1; tick(2); cnt_in = 1'b0; tick(WIN + 6);
    endtask

    task automatic lone_ref();
        ref_in = 1'b0; tick(2); ref_in = 1'b1; tick(WIN + 6);
    endtask

    task automatic double_cnt();
        cnt_in = 1'b1; tick(1); cnt_in = 1'b0; tick(2);
        cnt_in = 1'b1; tick(2); ref_in = 1'b0; tick(2);
        cnt_in = 1'b0; ref_in = 1'b1; tick(WIN + 6);
    endtask

    task automatic overlap();
        cnt_in = 1'b1; tick(1); cnt_in = 1'b0; tick(2);
        cnt_in = 1'b1; ref_in = 1'b0; tick(2);
        cnt_in = 1'b0; ref_in = 1'b1; tick(WIN + 6);
    endtask

    initial begin
        tick(1);
        do_reset();
        check("R7 flag low after reset", flag, 1'b0);

        pair(0); pair(0);
        check("R4 simultaneous edges pair", flag, 1'b0);
        pair(3); pair(1); pair(WIN); pair(WIN);
        check("R3 partners inside window", flag, 1'b0);

        lone_cnt(); lone_cnt();
        check("R1 two lone count edges", flag, 1'b0);
        cnt_in = 1'b1; tick(2); cnt_in = 1'b0; tick(WIN);
        check("R8 flag still low before latency", flag, 1'b0);
        tick(1);
        check("R8 flag high at latency", flag, 1'b1);
        check("R1 third lone count edge", flag, 1'b1);
        tick(WIN + 6);
        pair(2); lone_ref(); pair(0);
        check("R6 flag sticky", flag, 1'b1);

        do_reset();
        check("R7 reset clears flag", flag, 1'b0);
        lone_ref(); lone_ref();
        check("R2 two lone reference edges", flag, 1'b0);
        lone_ref();
        check("R2 third lone reference edge", flag, 1'b1);

        do_reset();
        pair(WIN + 1);
        check("R3 late partner two mismatches", flag, 1'b0);
        pair(WIN);
        check("R3 boundary partner matches", flag, 1'b0);
        lone_cnt();
        check("R3 late partner counted twice", flag, 1'b1);

        do_reset();
        double_cnt(); double_cnt();
        check("R5 repeated count edge", flag, 1'b0);
        double_cnt();
        check("R5 repeated count edge third", flag, 1'b1);

        do_reset();
        overlap(); overlap();
        check("R5 partner with new edge", flag, 1'b0);
        overlap();
        check("R5 partner with new edge third", flag, 1'b1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            finished = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL R6 watchdog expired: actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule